// File: doc/BRIEF.md
# Indexed Configuration Space Probe Engine

This block runs on the host side of a byte-wide I/O bus. It locates a security coprocessor that sits behind an index/data register pair, enables it, and reports where its I/O window is. A single start pulse launches a fixed sequence of indexed accesses. Every indexed access is a write of the register index to a base address, followed by a one-byte transfer at that base plus one. The block drives these through a request/acknowledge master port and keeps at most one access open at a time.

The engine first reads an identity byte at the primary base. If that byte does not match, it reads two bytes from a secondary configuration space and builds a fallback base from them. It then checks a second identity value at the fallback base. Once a device is accepted, the engine reads two 16-bit I/O bases from it and writes an enable value to its device-control index. When the sequence ends it gives a one-cycle done pulse and reports either found or error. It also reports whether the fallback path was taken.

Top module: `cfg_probe_engine`

## Requirements
- R1: An indexed access is two bus transfers. The first is a write (`bus_we`=1) of the index byte to the base address. The second is the data transfer at base+1. `bus_req` rises only with `bus_we`=1. Address, direction and write data stay stable until `bus_ack`. Only one transfer is open at a time.
- R2: The first access reads index 0x20 at the primary base 0x002E. A value of 0xEF accepts the device at that base, and the fallback path is not used.
- R3: Any other identity value, including 0xF6, makes the engine read index 0x2C and then index 0x2B at the secondary base 0x004E. The fallback base is {byte from 0x2C, byte from 0x2B with bit 0 forced to 0}.
- R4: At the fallback base, index 0x20 must read 0xF6. Any other value ends the probe with `err`=1 and `found`=0, and no further bus transfer is made.
- R5: For an accepted device, the engine reads indices 0x60, 0x61, 0x62 and 0x63 in that order at the chosen base. `dev_base0` = {0x60 byte, 0x61 byte} and `dev_base1` = {0x62 byte, 0x63 byte}.
- R6: After the four base reads, the last transfer of a successful probe writes 0x01 to index 0x30 at the chosen base.
- R7: `done` is a one-cycle pulse with exactly one of `found` and `err` set. `found`, `err`, `alt_used` and both bases hold their values until the next accepted start, which clears them.
- R8: `busy` is high from the cycle after an accepted start until the cycle in which `done` pulses. A start pulse while `busy` is high is ignored. No bus request is made while `busy` is low.
- R9: After reset all outputs are 0 and no bus request is made.
- R10: `alt_used` is 1 after a probe that took the fallback path, whether that probe succeeded or failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a probe |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe pulse |
| found | output | 1 | Device accepted and enabled |
| err | output | 1 | No device matched |
| alt_used | output | 1 | Fallback base path was taken |
| dev_base0 | output | 16 | First device I/O base |
| dev_base1 | output | 16 | Second device I/O base |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer complete |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |

## Verification
A wrong sequencer state shows up on the bus at the very next transfer: a wrong index byte, a wrong base, or a data phase that is not at base+1. The reference transfer list is compared at every acknowledge, so such a fault is flagged in the same cycle as that acknowledge. A corrupted captured byte stays hidden on the bus. It appears at the done pulse, either as a wrong base value or as the wrong choice between found and error. A fallback base with bit 0 left set shows up at the first fallback access, because that access goes to an odd address.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  // Probe sequencer states; order follows the access sequence.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRI_ID,
    ST_FB_HI,
    ST_FB_LO,
    ST_ALT_ID,
    ST_B0_HI,
    ST_B0_LO,
    ST_B1_HI,
    ST_B1_LO,
    ST_ENABLE
  } probe_st_t;

  // Phases of one indexed access on the bus.
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INDEX,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/cfgp_access.sv
module cfgp_access
  import cfgp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_go,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_base,
  input  logic [DATA_W-1:0] op_idx,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              op_done,
  output logic [DATA_W-1:0] op_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] DATA_OFS = {{(ADDR_W-1){1'b0}}, 1'b1};

  phase_t            ph;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      wr_q      <= 1'b0;
      base_q    <= '0;
      wd_q      <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      op_done   <= 1'b0;
      op_rdata  <= '0;
    end else begin
      op_done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (op_go) begin
          wr_q      <= op_wr;
          base_q    <= op_base;
          wd_q      <= op_wdata;
          bus_req   <= 1'b1;
          bus_we    <= 1'b1;
          bus_addr  <= op_base;
          bus_wdata <= op_idx;
          ph        <= PH_INDEX;
        end
        PH_INDEX: if (bus_ack) begin
          bus_addr  <= base_q + DATA_OFS;
          bus_we    <= wr_q;
          bus_wdata <= wr_q ? wd_q : '0;
          ph        <= PH_DATA;
        end
        PH_DATA: if (bus_ack) begin
          bus_req  <= 1'b0;
          bus_we   <= 1'b0;
          op_done  <= 1'b1;
          op_rdata <= bus_rdata;
          ph       <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgp_seq.sv
module cfgp_seq
  import cfgp_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter int                 DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  PRI_BASE  = 16'h002E,
  parameter logic [ADDR_W-1:0]  SEC_BASE  = 16'h004E,
  parameter logic [DATA_W-1:0]  ID_IDX    = 8'h20,
  parameter logic [DATA_W-1:0]  PRI_ID    = 8'hEF,
  parameter logic [DATA_W-1:0]  ALT_ID    = 8'hF6,
  parameter logic [DATA_W-1:0]  FB_HI_IDX = 8'h2C,
  parameter logic [DATA_W-1:0]  FB_LO_IDX = 8'h2B,
  parameter logic [DATA_W-1:0]  B0_IDX    = 8'h60,
  parameter logic [DATA_W-1:0]  B1_IDX    = 8'h62,
  parameter logic [DATA_W-1:0]  ENA_IDX   = 8'h30,
  parameter logic [DATA_W-1:0]  ENA_VAL   = 8'h01,
  localparam int                BASE_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_done,
  input  logic [DATA_W-1:0] op_rdata,
  output logic              op_go,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_base,
  output logic [DATA_W-1:0] op_idx,
  output logic [DATA_W-1:0] op_wdata,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              err,
  output logic              alt_used,
  output logic [BASE_W-1:0] dev_base0,
  output logic [BASE_W-1:0] dev_base1
);
  localparam logic [DATA_W-1:0] ONE_D   = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] LO_MASK = ~ONE_D;

  probe_st_t         st;
  logic [ADDR_W-1:0] cur_base;
  logic [DATA_W-1:0] fb_hi;
  logic [BASE_W-1:0] fb_raw;
  logic [ADDR_W-1:0] fb_base;

  assign fb_raw = {fb_hi, op_rdata & LO_MASK};

  // Fit the assembled fallback base to the bus address width.
  generate
    if (ADDR_W > BASE_W) begin : g_ext
      assign fb_base = {{(ADDR_W-BASE_W){1'b0}}, fb_raw};
    end else begin : g_cut
      assign fb_base = fb_raw[ADDR_W-1:0];
    end
  endgenerate

  // Access parameters follow the current state.
  always_comb begin
    op_wr    = (st == ST_ENABLE);
    op_wdata = ENA_VAL;
    op_base  = (st == ST_FB_HI || st == ST_FB_LO) ? SEC_BASE : cur_base;
    unique case (st)
      ST_FB_HI: op_idx = FB_HI_IDX;
      ST_FB_LO: op_idx = FB_LO_IDX;
      ST_B0_HI: op_idx = B0_IDX;
      ST_B0_LO: op_idx = B0_IDX + ONE_D;
      ST_B1_HI: op_idx = B1_IDX;
      ST_B1_LO: op_idx = B1_IDX + ONE_D;
      ST_ENABLE: op_idx = ENA_IDX;
      default:  op_idx = ID_IDX;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur_base  <= '0;
      fb_hi     <= '0;
      op_go     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      found     <= 1'b0;
      err       <= 1'b0;
      alt_used  <= 1'b0;
      dev_base0 <= '0;
      dev_base1 <= '0;
    end else begin
      op_go <= 1'b0;
      done  <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st        <= ST_PRI_ID;
          cur_base  <= PRI_BASE;
          op_go     <= 1'b1;
          busy      <= 1'b1;
          found     <= 1'b0;
          err       <= 1'b0;
          alt_used  <= 1'b0;
          dev_base0 <= '0;
          dev_base1 <= '0;
        end
      end else if (op_done) begin
        op_go <= 1'b1;
        unique case (st)
          ST_PRI_ID: st <= (op_rdata == PRI_ID) ? ST_B0_HI : ST_FB_HI;
          ST_FB_HI: begin
            fb_hi <= op_rdata;
            st    <= ST_FB_LO;
          end
          ST_FB_LO: begin
            cur_base <= fb_base;
            alt_used <= 1'b1;
            st       <= ST_ALT_ID;
          end
          ST_ALT_ID: begin
            if (op_rdata == ALT_ID) begin
              st <= ST_B0_HI;
            end else begin
              op_go <= 1'b0;
              busy  <= 1'b0;
              done  <= 1'b1;
              err   <= 1'b1;
              st    <= ST_IDLE;
            end
          end
          ST_B0_HI: begin
            dev_base0[BASE_W-1:DATA_W] <= op_rdata;
            st <= ST_B0_LO;
          end
          ST_B0_LO: begin
            dev_base0[DATA_W-1:0] <= op_rdata;
            st <= ST_B1_HI;
          end
          ST_B1_HI: begin
            dev_base1[BASE_W-1:DATA_W] <= op_rdata;
            st <= ST_B1_LO;
          end
          ST_B1_LO: begin
            dev_base1[DATA_W-1:0] <= op_rdata;
            st <= ST_ENABLE;
          end
          ST_ENABLE: begin
            op_go <= 1'b0;
            busy  <= 1'b0;
            done  <= 1'b1;
            found <= 1'b1;
            st    <= ST_IDLE;
          end
          default: begin
            op_go <= 1'b0;
            st    <= ST_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_probe_engine.sv
module cfg_probe_engine #(
  parameter int                 ADDR_W    = 16,
  parameter int                 DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  PRI_BASE  = 16'h002E,
  parameter logic [ADDR_W-1:0]  SEC_BASE  = 16'h004E,
  parameter logic [DATA_W-1:0]  ID_IDX    = 8'h20,
  parameter logic [DATA_W-1:0]  PRI_ID    = 8'hEF,
  parameter logic [DATA_W-1:0]  ALT_ID    = 8'hF6,
  parameter logic [DATA_W-1:0]  FB_HI_IDX = 8'h2C,
  parameter logic [DATA_W-1:0]  FB_LO_IDX = 8'h2B,
  parameter logic [DATA_W-1:0]  B0_IDX    = 8'h60,
  parameter logic [DATA_W-1:0]  B1_IDX    = 8'h62,
  parameter logic [DATA_W-1:0]  ENA_IDX   = 8'h30,
  parameter logic [DATA_W-1:0]  ENA_VAL   = 8'h01,
  localparam int                BASE_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic              err,
  output logic              alt_used,
  output logic [BASE_W-1:0] dev_base0,
  output logic [BASE_W-1:0] dev_base1,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic              op_go;
  logic              op_wr;
  logic [ADDR_W-1:0] op_base;
  logic [DATA_W-1:0] op_idx;
  logic [DATA_W-1:0] op_wdata;
  logic              op_done;
  logic [DATA_W-1:0] op_rdata;

  cfgp_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRI_BASE(PRI_BASE), .SEC_BASE(SEC_BASE),
    .ID_IDX(ID_IDX), .PRI_ID(PRI_ID), .ALT_ID(ALT_ID), .FB_HI_IDX(FB_HI_IDX),
    .FB_LO_IDX(FB_LO_IDX), .B0_IDX(B0_IDX), .B1_IDX(B1_IDX),
    .ENA_IDX(ENA_IDX), .ENA_VAL(ENA_VAL)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .op_done(op_done), .op_rdata(op_rdata),
    .op_go(op_go), .op_wr(op_wr), .op_base(op_base), .op_idx(op_idx),
    .op_wdata(op_wdata),
    .busy(busy), .done(done), .found(found), .err(err), .alt_used(alt_used),
    .dev_base0(dev_base0), .dev_base1(dev_base1)
  );

  cfgp_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst(rst),
    .op_go(op_go), .op_wr(op_wr), .op_base(op_base), .op_idx(op_idx),
    .op_wdata(op_wdata), .op_done(op_done), .op_rdata(op_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic              err,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  // R1: an open transfer keeps its request and contents until acknowledged
  a_r1_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  // R1: every new request starts with the index write
  a_r1_index_first: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> bus_we);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: exactly one outcome flag with done
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> (found != err));

  // R8: no bus activity while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);

  // R8: busy ends only together with done
  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind cfg_probe_engine cfgp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .found(found), .err(err),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sim_cfg_probe_engine.sv
module sim_cfg_probe_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, found, err, alt_used;
  logic [15:0] dev_base0, dev_base1;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ack = 1'b0;
  logic [7:0]  bus_rdata = 8'h00;

  always #4 clk = ~clk;

  cfg_probe_engine u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .found(found), .err(err), .alt_used(alt_used),
    .dev_base0(dev_base0), .dev_base1(dev_base1),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // Slave register space, keyed by {base, index}
  logic [7:0] mem [int];
  int         wait_n = 0;
  int         wcnt = 0;
  logic       s_data_ph = 1'b0;
  logic [15:0] s_base = 16'h0;
  logic [7:0]  s_idx = 8'h0;

  function automatic int key(input logic [15:0] b, input logic [7:0] i);
    return int'({b, i});
  endfunction

  function automatic logic [7:0] rd(input int k);
    if (mem.exists(k)) return mem[k];
    return 8'hFF;
  endfunction

  // Bus slave: ack after wait_n idle cycles, one-cycle ack pulse
  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; wcnt <= 0; s_data_ph <= 1'b0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
    end else if (bus_req) begin
      if (wcnt >= wait_n) begin
        wcnt <= 0;
        bus_ack <= 1'b1;
        if (!s_data_ph) begin
          s_base <= bus_addr; s_idx <= bus_wdata; s_data_ph <= 1'b1;
        end else begin
          s_data_ph <= 1'b0;
          if (!bus_we) bus_rdata <= rd(key(s_base, s_idx));
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  typedef struct { logic [15:0] a; logic w; logic [7:0] d; } xfer_t;
  xfer_t exp_q[$];
  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic exp_rd(input logic [15:0] b, input logic [7:0] i);
    exp_q.push_back('{b, 1'b1, i});
    exp_q.push_back('{b + 16'd1, 1'b0, 8'h00});
  endtask

  task automatic exp_wr(input logic [15:0] b, input logic [7:0] i, input logic [7:0] v);
    exp_q.push_back('{b, 1'b1, i});
    exp_q.push_back('{b + 16'd1, 1'b1, v});
  endtask

  task automatic exp_accept(input logic [15:0] b);
    exp_rd(b, 8'h60); exp_rd(b, 8'h61); exp_rd(b, 8'h62); exp_rd(b, 8'h63);
    exp_wr(b, 8'h30, 8'h01);
  endtask

  // Per-clock comparison against the reference transfer list
  task automatic monitor();
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!busy && bus_req) check(1'b0, "R8 request while idle", 1, 0);
        if (bus_req && bus_ack) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected transfer", longint'(bus_addr), 0);
          end else begin
            xfer_t e;
            e = exp_q.pop_front();
            check(bus_addr == e.a, "R1 transfer address", longint'(bus_addr), longint'(e.a));
            check(bus_we == e.w, "R1 transfer direction", longint'(bus_we), longint'(e.w));
            if (e.w)
              check(bus_wdata == e.d, "R1 transfer data", longint'(bus_wdata), longint'(e.d));
          end
        end
      end
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_up();
  endtask

  task automatic run(input bit xf, input bit xe, input bit xalt,
                     input logic [15:0] xb0, input logic [15:0] xb1,
                     input bit dbl, input string tag);
    bit seen;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, {tag, " R8 busy after start"}, longint'(busy), 1);
    check(found == 1'b0 && err == 1'b0, {tag, " R7 flags cleared by start"},
          longint'({found, err}), 0);
    if (dbl) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      check(busy == 1'b1, {tag, " R8 second start ignored"}, longint'(busy), 1);
    end
    seen = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, {tag, " R7 done timeout"}, 0, 1);
    if (seen) begin
      check(found == xf, {tag, " R7 found"}, longint'(found), longint'(xf));
      check(err == xe, {tag, " R4 err"}, longint'(err), longint'(xe));
      check(busy == 1'b0, {tag, " R8 busy low at done"}, longint'(busy), 0);
      check(alt_used == xalt, {tag, " R10 alt_used"}, longint'(alt_used), longint'(xalt));
      check(dev_base0 == xb0, {tag, " R5 base0"}, longint'(dev_base0), longint'(xb0));
      check(dev_base1 == xb1, {tag, " R5 base1"}, longint'(dev_base1), longint'(xb1));
      check(exp_q.size() == 0, {tag, " R6 all transfers made"}, exp_q.size(), 0);
      @(negedge clk);
      check(done == 1'b0, {tag, " R7 done one cycle"}, longint'(done), 0);
      repeat (4) @(negedge clk);
      check(found == xf && err == xe && dev_base0 == xb0, {tag, " R7 outputs hold"},
            longint'({found, err}), longint'({xf, xe}));
      check(bus_req == 1'b0, {tag, " R4 no transfer after end"}, longint'(bus_req), 0);
    end
    exp_q.delete();
  endtask

  initial begin
    fork
      monitor();
      watchdog();
    join_none
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check({busy, done, found, err, alt_used, bus_req} == 6'b0, "R9 reset flags",
          longint'({busy, done, found, err, alt_used, bus_req}), 0);
    check(dev_base0 == 16'h0 && dev_base1 == 16'h0, "R9 reset bases",
          longint'({dev_base0, dev_base1}), 0);

    // Case A, R2: primary identity matches
    wait_n = 0;
    mem[key(16'h002E, 8'h20)] = 8'hEF;
    mem[key(16'h002E, 8'h60)] = 8'hAB; mem[key(16'h002E, 8'h61)] = 8'hCD;
    mem[key(16'h002E, 8'h62)] = 8'h01; mem[key(16'h002E, 8'h63)] = 8'h02;
    exp_rd(16'h002E, 8'h20);
    exp_accept(16'h002E);
    run(1'b1, 1'b0, 1'b0, 16'hABCD, 16'h0102, 1'b0, "R2 primary");

    // Case B, R3: primary reads 0xF6 (not accepted there), fallback 0x1234 with odd low byte
    wait_n = 2;
    mem[key(16'h002E, 8'h20)] = 8'hF6;
    mem[key(16'h004E, 8'h2C)] = 8'h12; mem[key(16'h004E, 8'h2B)] = 8'h35;
    mem[key(16'h1234, 8'h20)] = 8'hF6;
    mem[key(16'h1234, 8'h60)] = 8'h55; mem[key(16'h1234, 8'h61)] = 8'h66;
    mem[key(16'h1234, 8'h62)] = 8'h77; mem[key(16'h1234, 8'h63)] = 8'h88;
    exp_rd(16'h002E, 8'h20);
    exp_rd(16'h004E, 8'h2C); exp_rd(16'h004E, 8'h2B);
    exp_rd(16'h1234, 8'h20);
    exp_accept(16'h1234);
    run(1'b1, 1'b0, 1'b1, 16'h5566, 16'h7788, 1'b1, "R3 fallback");

    // Case C, R4: fallback identity 0xEF is rejected
    wait_n = 1;
    mem[key(16'h002E, 8'h20)] = 8'h00;
    mem[key(16'h004E, 8'h2C)] = 8'h03; mem[key(16'h004E, 8'h2B)] = 8'h41;
    mem[key(16'h0340, 8'h20)] = 8'hEF;
    exp_rd(16'h002E, 8'h20);
    exp_rd(16'h004E, 8'h2C); exp_rd(16'h004E, 8'h2B);
    exp_rd(16'h0340, 8'h20);
    run(1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, "R4 reject");

    // Case D, R6: primary again after an error, new base values
    wait_n = 3;
    mem[key(16'h002E, 8'h20)] = 8'hEF;
    mem[key(16'h002E, 8'h60)] = 8'h9A; mem[key(16'h002E, 8'h61)] = 8'hBC;
    mem[key(16'h002E, 8'h62)] = 8'hDE; mem[key(16'h002E, 8'h63)] = 8'hF0;
    exp_rd(16'h002E, 8'h20);
    exp_accept(16'h002E);
    run(1'b1, 1'b0, 1'b0, 16'h9ABC, 16'hDEF0, 1'b0, "R6 rerun");

    finish_up();
  end
endmodule